// File: doc/BRIEF.md
# Pulse Position Modulator Transmitter

This block sends data words over an optical link by pulse position. Each accepted word opens one symbol frame of fixed length. The frame is split into 2^DATA_W slots of equal length, one for every possible word value. The block emits one pulse per frame, and the pulse starts in the slot whose index equals the word. The line level carries no information. Only the position of the rising edge in the frame does.

All timing comes from counters on the single system clock. No derived clock is used. With the defaults (8-bit words, 811-tick slots on a 50 MHz clock) a slot lasts about 16.22 us and a frame of 256 slots lasts about 4.15 ms. The pulse width is its own parameter and has no effect on frame length or throughput. A width greater than the slot length, or below one tick, stops elaboration. A small setting of 2-bit words, 4-tick slots and 2-tick pulses is also supported. Words arrive over a valid/ready handshake, and one serial line drives the emitter.

Top module: `ppm_tx`

## Requirements
- R1: A synchronous active-high reset, applied at any time, forces `pulse_out` low and returns the block to idle. In the cycle after reset is released, `in_ready` is high.
- R2: `in_ready` is high while the block is idle or during the last tick of a frame. It is low at every other tick of a frame.
- R3: A word D accepted at a clock edge starts a frame in the next cycle (frame offset 0). `pulse_out` rises at offset D*SLOT_TICKS, which is the first tick of slot D. The slot index is the unsigned value of `in_data`.
- R4: `pulse_out` stays high for exactly PULSE_TICKS cycles and is low at every other offset of that frame.
- R5: A frame lasts exactly 2^DATA_W * SLOT_TICKS cycles. A word accepted during the last tick starts the next frame in the very next cycle, with no gap between frames.
- R6: If no word is valid during the last tick of a frame, the block goes idle and `pulse_out` stays low until a word is accepted.
- R7: Changes on `in_data` after acceptance have no effect on the frame in progress. The pulse position follows the word captured at the handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data word is offered |
| in_data | input | DATA_W | Data word; its value selects the pulse slot |
| in_ready | output | 1 | The block accepts a word at this edge |
| pulse_out | output | 1 | Serial line to the optical emitter |

## Verification
The assertions assume the source obeys the handshake. Once `in_valid` is raised, the source holds it and `in_data` steady until the word is accepted. They also assume that reset is a clean synchronous level. The stimulus follows these rules. Its send task holds a word until the reference model predicts acceptance, and it changes `in_data` only while `in_valid` is low. That freedom is used to scramble the data lines during frames. Reset is pulsed only at falling edges, including once in the middle of a frame.

// File: rtl/ppm_tx.sv
module ppm_tx #(
  parameter int DATA_W      = 8,
  parameter int SLOT_TICKS  = 811,
  parameter int PULSE_TICKS = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              pulse_out
);
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TW-1:0]     TICK_LAST = TW'(SLOT_TICKS - 1);
  localparam logic [TW:0]       PULSE_LIM = (TW+1)'(PULSE_TICKS);
  localparam logic [DATA_W-1:0] SLOT_LAST = '1;

  generate
    if (PULSE_TICKS < 1 || PULSE_TICKS > SLOT_TICKS) begin : g_bad_width
      $error("ppm_tx: PULSE_TICKS must lie in 1..SLOT_TICKS");
    end
  endgenerate

  logic              busy;
  logic [TW-1:0]     tick_cnt;
  logic [DATA_W-1:0] slot_cnt;
  logic [DATA_W-1:0] data_q;

  wire tick_end  = (tick_cnt == TICK_LAST);
  wire frame_end = busy && tick_end && (slot_cnt == SLOT_LAST);
  wire accept    = in_valid && in_ready;

  assign in_ready  = !busy || frame_end;
  assign pulse_out = busy && (slot_cnt == data_q) && ({1'b0, tick_cnt} < PULSE_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
      slot_cnt <= '0;
      data_q   <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      tick_cnt <= '0;
      slot_cnt <= '0;
      data_q   <= in_data;
    end else if (frame_end) begin
      busy     <= 1'b0;
      tick_cnt <= '0;
      slot_cnt <= '0;
    end else if (busy) begin
      if (tick_end) begin
        tick_cnt <= '0;
        slot_cnt <= slot_cnt + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !busy && !pulse_out && in_ready);

  assert_accept_starts_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && tick_cnt == '0 && slot_cnt == '0 && data_q == $past(in_data));

  assert_rise_at_slot_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> tick_cnt == '0 && slot_cnt == data_q);

  assert_pulse_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse_out && {1'b0, tick_cnt} == PULSE_LIM - 1'b1 && !accept) |=> !pulse_out);

  assert_idle_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !in_valid) |=> !busy && !pulse_out);

  assert_data_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> $stable(data_q));
endmodule

// File: tb/tb_ppm_tx.sv
module tb_ppm_tx;
  localparam int DW    = 2;
  localparam int SLOT  = 4;
  localparam int PULSE = 2;
  localparam int FRAME = (1 << DW) * SLOT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, pulse_out;

  int checks = 0, fails = 0, cycles = 0;

  // reference state, advanced at each rising edge from the requirements
  logic m_busy = 1'b0;
  logic m_rst  = 1'b1;
  int   m_off  = 0;
  int   m_data = 0;

  ppm_tx #(.DATA_W(DW), .SLOT_TICKS(SLOT), .PULSE_TICKS(PULSE)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pulse_out(pulse_out));

  always #2 clk = ~clk;

  function automatic logic exp_ready();
    return !m_busy || (m_off == FRAME - 1);
  endfunction

  function automatic logic exp_pulse();
    return m_busy && m_off >= m_data * SLOT && m_off < m_data * SLOT + PULSE;
  endfunction

  always @(posedge clk) begin
    cycles++;
    m_rst = rst;
    if (rst) begin
      m_busy = 1'b0; m_off = 0;
    end else if (in_valid && exp_ready()) begin
      m_busy = 1'b1; m_off = 0; m_data = int'(in_data);
    end else if (m_busy) begin
      if (m_off == FRAME - 1) m_busy = 1'b0;
      else m_off++;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (m_rst) begin
        check(pulse_out, 1'b0, "R1 pulse after reset");
        check(in_ready, 1'b1, "R1 ready after reset");
      end else begin
        check(in_ready, exp_ready(), m_busy && m_off == FRAME - 1 ? "R5 ready on last tick" : "R2 ready");
        if (!m_busy) check(pulse_out, exp_pulse(), "R6 idle line");
        else if (int'(in_data) != m_data) check(pulse_out, exp_pulse(), "R7 pulse vs captured word");
        else if (exp_pulse()) check(pulse_out, exp_pulse(), "R3 pulse position");
        else check(pulse_out, exp_pulse(), "R4 pulse width");
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic send(input int d);
    logic acc;
    in_valid = 1'b1;
    in_data  = DW'(d);
    do begin
      acc = exp_ready();
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_data = DW'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // directed corners: lowest slot, highest slot, back-to-back, gaps
    send(0);
    idle(FRAME + 3);
    send((1 << DW) - 1);
    send(0);
    send(1);
    idle(3);
    send(2);
    idle(FRAME + 2);
    // reset in the middle of a frame
    send(3);
    idle(FRAME / 2 + 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    // constrained random traffic
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 4 == 0) idle($urandom % (FRAME + 4));
      send($urandom % (1 << DW));
    end
    idle(FRAME + 4);
    finish_run();
  end
endmodule